// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, each cycle, which hardware thread owns the instruction fetch slot. It looks at the fetch state of every thread, a mask of the threads that are active, the occupancy counts that each thread holds in the instruction queue and in the load/store queue, and a policy code. From these it produces a thread number and a valid flag. When the flag is low, fetch stays idle for that cycle.

The selection is combinational on the current inputs. The round-robin policy also keeps an ordered list of thread numbers in registers. When round-robin picks a thread, that thread moves to the tail of the list at the next clock edge, and the threads behind it each move one place forward. The other policies are stateless. The count policies favour the thread that holds the fewest queue entries. When the block is built for a single thread, it ignores the policy code altogether.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread can be picked by the round-robin and count policies only when its active bit is set and its 3-bit state is running (0), idle (1) or miss-done (5). The codes blocked (2), squashing (3), miss-wait (4), quiesce (6) and trap (7) make a thread ineligible.
- R2: Policy code 0 (single-thread) always gives valid high with thread 0, whatever the states and the active mask.
- R3: Policy code 1 (round-robin) scans the order list from its head and picks the first thread that is eligible.
- R4: When round-robin picks a thread, that thread moves to the tail of the list at the next clock edge, and the entries behind it shift forward by one place. The list does not change when round-robin finds no eligible thread, and it does not change in any cycle that uses another policy.
- R5: After reset, the order list holds the thread numbers in ascending order, with thread 0 at the head.
- R6: Policy code 2 picks the eligible thread with the smallest instruction-queue count. A tie goes to the lower thread number.
- R7: Policy code 3 picks the eligible thread with the smallest load/store-queue count. A tie goes to the lower thread number.
- R8: Policy code 4 (branch count) returns the lowest-numbered active thread, whatever its state. Valid is high exactly when at least one thread is active.
- R9: Policy codes 5, 6 and 7 give valid low.
- R10: When the round-robin or count policies find no eligible thread, valid is low.
- R11: When the block is built with one thread, it ignores the policy code. Valid is high with thread 0 exactly when thread 0 is active and its state is eligible under R1.
- R12: Whenever valid is low, the thread output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 3 | Selection policy code |
| active | input | NUM_THREADS | Per-thread active mask |
| thr_state | input | 3*NUM_THREADS | Per-thread fetch state, thread i in bits [3i+2:3i] |
| iq_cnt | input | CNT_W*NUM_THREADS | Per-thread instruction-queue occupancy, thread i in slice i |
| lsq_cnt | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy, thread i in slice i |
| sel_valid | output | 1 | A thread was selected this cycle |
| sel_tid | output | TID_W | Selected thread number |

## Verification
The bench builds two instances. The first uses four threads with 6-bit counts. Four threads are enough to rotate the order list through several distinct arrangements, to place an ineligible or inactive thread at its head, and to produce ties in both occupancy counts. The second uses a single thread. That instance reaches the variant in which the policy code is ignored, so the bench can show that an otherwise invalid code still yields thread 0.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_BLOCK     = 3'd2,
        ST_SQUASH    = 3'd3,
        ST_MISS_WAIT = 3'd4,
        ST_MISS_DONE = 3'd5,
        ST_QUIESCE   = 3'd6,
        ST_TRAP      = 3'd7
    } fstate_e;

    typedef enum logic [2:0] {
        POL_SINGLE = 3'd0,
        POL_RR     = 3'd1,
        POL_IQ     = 3'd2,
        POL_LSQ    = 3'd3,
        POL_BRANCH = 3'd4
    } policy_e;

    function automatic logic can_fetch(input logic [2:0] st);
        return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_MISS_DONE);
    endfunction

endpackage

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    input  logic             advance,
    output logic             hit,
    output logic [TID_W-1:0] pick
);
    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        tid_t [N-1:0] order;
    } rr_state_t;

    rr_state_t state_d, state_q;
    int        pos;

    always_comb begin
        hit     = 1'b0;
        pos     = 0;
        state_d = state_q;
        for (int i = 0; i < N; i++) begin
            if (!hit && elig[state_q.order[i]]) begin
                hit = 1'b1;
                pos = i;
            end
        end
        pick = hit ? state_q.order[pos] : '0;
        if (advance && hit) begin
            for (int j = 0; j < N - 1; j++) begin
                if (j >= pos) state_d.order[j] = state_q.order[j+1];
            end
            state_d.order[N-1] = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) state_q.order[i] <= tid_t'(i);
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int TID_W = 2
) (
    input  logic [N*CNT_W-1:0] cnt,
    input  logic [N-1:0]       elig,
    output logic               hit,
    output logic [TID_W-1:0]   pick
);
    logic [CNT_W-1:0] best;

    always_comb begin
        hit  = 1'b0;
        best = '0;
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!hit || cnt[i*CNT_W +: CNT_W] < best)) begin
                hit  = 1'b1;
                best = cnt[i*CNT_W +: CNT_W];
                pick = TID_W'(i);
            end
        end
    end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   policy,
    input  logic [NUM_THREADS-1:0]       active,
    input  logic [3*NUM_THREADS-1:0]     thr_state,
    input  logic [CNT_W*NUM_THREADS-1:0] iq_cnt,
    input  logic [CNT_W*NUM_THREADS-1:0] lsq_cnt,
    output logic                         sel_valid,
    output logic [TID_W-1:0]             sel_tid
);
    import fts_pkg::*;

    logic [NUM_THREADS-1:0] elig;
    logic                   rr_hit, iq_hit, lsq_hit, first_hit;
    logic [TID_W-1:0]       rr_tid, iq_tid, lsq_tid, first_tid;
    logic                   rr_adv;

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_elig
        assign elig[g] = active[g] && can_fetch(thr_state[3*g +: 3]);
    end

    assign rr_adv = (NUM_THREADS > 1) && (policy == POL_RR);

    fts_rr_list #(.N(NUM_THREADS), .TID_W(TID_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .advance (rr_adv),
        .hit     (rr_hit),
        .pick    (rr_tid)
    );

    fts_min_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_iq (
        .cnt  (iq_cnt),
        .elig (elig),
        .hit  (iq_hit),
        .pick (iq_tid)
    );

    fts_min_pick #(.N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_lsq (
        .cnt  (lsq_cnt),
        .elig (elig),
        .hit  (lsq_hit),
        .pick (lsq_tid)
    );

    always_comb begin
        first_hit = |active;
        first_tid = '0;
        for (int i = NUM_THREADS - 1; i >= 0; i--) begin
            if (active[i]) first_tid = TID_W'(i);
        end
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_tid   = '0;
        if (NUM_THREADS == 1) begin
            sel_valid = elig[0];
        end else begin
            case (policy)
                POL_SINGLE: sel_valid = 1'b1;
                POL_RR:     begin sel_valid = rr_hit;    sel_tid = rr_tid;    end
                POL_IQ:     begin sel_valid = iq_hit;    sel_tid = iq_tid;    end
                POL_LSQ:    begin sel_valid = lsq_hit;   sel_tid = lsq_tid;   end
                POL_BRANCH: begin sel_valid = first_hit; sel_tid = first_tid; end
                default:    sel_valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fetch_thread_sel_chk.sv
module fetch_thread_sel_chk #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       policy,
    input logic [N-1:0]     active,
    input logic [3*N-1:0]   thr_state,
    input logic             sel_valid,
    input logic [TID_W-1:0] sel_tid
);
    logic       sel_act;
    logic [2:0] sel_st;
    logic       sel_ok;

    assign sel_act = active[sel_tid];
    assign sel_st  = thr_state[sel_tid*3 +: 3];
    assign sel_ok  = sel_act && (sel_st == 3'd0 || sel_st == 3'd1 || sel_st == 3'd5);

    assert_idle_tid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_tid == '0);

    if (N > 1) begin : g_multi
        assert_pick_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_valid && (policy == 3'd1 || policy == 3'd2 || policy == 3'd3)) |-> sel_ok);

        assert_single_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            policy == 3'd0 |-> (sel_valid && sel_tid == '0));

        assert_branch_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
            policy == 3'd4 |-> (sel_valid == (|active)) && (!sel_valid || sel_act));

        assert_unknown_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
            policy >= 3'd5 |-> !sel_valid);
    end else begin : g_one
        assert_one_thread_R11: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid == (active[0] && (thr_state[2:0] == 3'd0 || thr_state[2:0] == 3'd1
                                        || thr_state[2:0] == 3'd5)));
    end

endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(.N(NUM_THREADS), .TID_W(TID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .policy    (policy),
    .active    (active),
    .thr_state (thr_state),
    .sel_valid (sel_valid),
    .sel_tid   (sel_tid)
);

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  policy = '0;
    logic [3:0]  active = '0;
    logic [11:0] thr_state = '0;
    logic [23:0] iq_cnt = '0;
    logic [23:0] lsq_cnt = '0;
    logic        sel_valid;
    logic [1:0]  sel_tid;

    logic [2:0]  p1 = '0;
    logic        a1 = 1'b0;
    logic [2:0]  s1 = '0;
    logic        v1;
    logic [0:0]  t1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fetch_thread_sel #(.NUM_THREADS(4), .CNT_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .active(active),
        .thr_state(thr_state), .iq_cnt(iq_cnt), .lsq_cnt(lsq_cnt),
        .sel_valid(sel_valid), .sel_tid(sel_tid)
    );

    fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(6)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .policy(p1), .active(a1),
        .thr_state(s1), .iq_cnt(6'd3), .lsq_cnt(6'd4),
        .sel_valid(v1), .sel_tid(t1)
    );

    typedef struct packed {
        logic [2:0]  pol;
        logic [3:0]  act;
        logic [11:0] st;
        logic [23:0] iq;
        logic [23:0] lsq;
        logic        ev;
        logic [1:0]  et;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    // states in octal, one digit per thread, thread 3 leftmost
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'hF, 12'o7777, 24'd0, 24'd0, 1'b1, 2'd0, 4'd2},   // R2
        '{3'd1, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd0, 4'd3},   // R3 list 0123 -> 1230
        '{3'd1, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd1, 4'd4},   // R4 -> 2301
        '{3'd1, 4'hF, 12'o0200, 24'd0, 24'd0, 1'b1, 2'd3, 4'd1},   // R1 head blocked -> 2013
        '{3'd1, 4'hB, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd0, 4'd1},   // R1 head inactive -> 2130
        '{3'd1, 4'hF, 12'o7777, 24'd0, 24'd0, 1'b0, 2'd0, 4'd10},  // R10 no change
        '{3'd1, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd2, 4'd4},   // R4 -> 1302
        '{3'd2, 4'hF, 12'o0000, {6'd5,6'd1,6'd1,6'd9}, 24'd0, 1'b1, 2'd1, 4'd6},  // R6 tie
        '{3'd2, 4'hF, 12'o0040, {6'd5,6'd1,6'd1,6'd9}, 24'd0, 1'b1, 2'd2, 4'd6},  // R6 miss-wait
        '{3'd3, 4'hF, 12'o1050, 24'd0, {6'd0,6'd3,6'd0,6'd2}, 1'b1, 2'd1, 4'd7},  // R7 tie
        '{3'd3, 4'h8, 12'o1050, 24'd0, {6'd0,6'd3,6'd0,6'd2}, 1'b1, 2'd3, 4'd7},  // R7 mask
        '{3'd4, 4'h4, 12'o7777, 24'd0, 24'd0, 1'b1, 2'd2, 4'd8},   // R8
        '{3'd4, 4'h0, 12'o0000, 24'd0, 24'd0, 1'b0, 2'd0, 4'd8},   // R8 none active
        '{3'd5, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b0, 2'd0, 4'd9},   // R9
        '{3'd7, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b0, 2'd0, 4'd9},   // R9
        '{3'd1, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd1, 4'd4},   // R4 list held 1302 -> 3021
        '{3'd1, 4'hF, 12'o0000, 24'd0, 24'd0, 1'b1, 2'd3, 4'd4}    // R4
    };

    task automatic check(input string tag, input logic gv, input logic [1:0] gt,
                         input logic ev, input logic [1:0] et);
        checks++;
        if (gv !== ev || gt !== et) begin
            errors++;
            $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                     tag, gv, gt, ev, et);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            policy    = VECS[k].pol;
            active    = VECS[k].act;
            thr_state = VECS[k].st;
            iq_cnt    = VECS[k].iq;
            lsq_cnt   = VECS[k].lsq;
            #1;
            check($sformatf("R%0d vec%0d", VECS[k].req, k), sel_valid, sel_tid,
                  VECS[k].ev, VECS[k].et);
            @(negedge clk);
        end

        // R5: reset restores ascending order
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        policy = 3'd1; active = 4'hF; thr_state = 12'o0000;
        #1;
        check("R5 head after reset", sel_valid, sel_tid, 1'b1, 2'd0);
        @(negedge clk);
        #1;
        check("R5 second after reset", sel_valid, sel_tid, 1'b1, 2'd1);
        @(negedge clk);

        // R12: tid zero when no selection under round-robin
        thr_state = 12'o2222;
        #1;
        check("R12 tid cleared", sel_valid, sel_tid, 1'b0, 2'd0);
        @(negedge clk);

        // R11: single-thread build ignores policy
        p1 = 3'd3; a1 = 1'b1; s1 = 3'd0;
        #1;
        check("R11 running", v1, {1'b0, t1}, 1'b1, 2'd0);
        s1 = 3'd2;
        #1;
        check("R11 blocked", v1, {1'b0, t1}, 1'b0, 2'd0);
        s1 = 3'd5; a1 = 1'b0;
        #1;
        check("R11 inactive", v1, {1'b0, t1}, 1'b0, 2'd0);
        p1 = 3'd6; a1 = 1'b1; s1 = 3'd1;
        #1;
        check("R11 unknown code ignored", v1, {1'b0, t1}, 1'b1, 2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule